// File: doc/BRIEF.md
# Power-Rail Control Register Target on I2C

This block is the serial control front end of a multi-rail supply controller. It samples the two-wire bus lines on the system clock, recognises its own 7-bit device address and holds three 8-bit control registers. The outputs of these registers drive the rail enables, the per-rail voltage selects, the detector threshold selects and the mode of the status pin. Comparator results from the analog side come in as digital flags, and a read of the device returns them.

A write transaction carries a sub-address and exactly one data byte. There is no address auto-increment. A read transaction carries no sub-address. It returns two bytes: the voltage-select register, then a snapshot of the six fault flags. A rail's voltage-select field changes only while that rail is disabled. An overvoltage-protection trip clears the enable register, and the rails stay off afterwards. A supervisor reset clears every register.

Top module: `pwr_i2c_regs`

## Requirements
- R1: During and after reset every register output is 0, and `sda_oe` is low.
- R2: Only device address 0001000 is acknowledged (bytes are sent MSB first, and the R/W bit 0 means write). A transaction to any other address gets no acknowledge and changes no register.
- R3: A write to sub-address 00h loads the rail enables from data bit 7 (ILM, `rail_en[4]`), bit 6 (CD, `rail_en[3]`), bit 5 (AUDIO, `rail_en[2]`), bit 4 (SYS, `rail_en[1]`) and bit 3 (AMP, `rail_en[0]`). Data bits 2..0 are ignored.
- R4: A write to sub-address 01h loads the voltage-select fields ILM from [7:6], CD from [5:4], AUDIO from [3:2] and SYS from bit 1, provided each field's rail is disabled. Bit 0 is ignored.
- R5: A voltage-select field whose rail enable is 1 at the time of the write keeps its old value. The other fields in the same write still update.
- R6: A write to sub-address 02h loads the ACC threshold select from [7:6], the undervoltage threshold select from [5:4] and the status-pin mode from bit 3. Bits 2..0 are ignored.
- R7: A write accepts exactly one data byte. A further data byte is not acknowledged and writes no register.
- R8: A write to a sub-address above 02h is acknowledged for both the sub-address and the data byte, and changes no register.
- R9: A read (R/W bit 1) returns two bytes. The first is the voltage-select byte in the 01h layout with bit 0 = 0. The second holds `flag_in[5:0]` in bits 7..2, with bits 1..0 = 0.
- R10: The flag byte is captured when the first read byte is loaded. A flag change after that point does not alter the second byte of the same read.
- R11: While `ovp_trip` is high the rail enables are cleared and writes to them are blocked. They remain 0 after `ovp_trip` falls. The other registers are kept.
- R12: `sup_rst` clears all three registers and returns the bus engine to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | Pull data line low when 1 |
| sup_rst | input | 1 | Supervisor reset, synchronous, clears all registers |
| ovp_trip | input | 1 | Overvoltage-protection trip, clears rail enables |
| flag_in | input | 6 | Fault flags: ACC UV, UV, OV, OVP, thermal warn, overcurrent |
| rail_en | output | 5 | Enables ILM, CD, AUDIO, SYS, AMP (bit 4 down to 0) |
| ilm_vsel | output | 2 | ILM voltage select |
| cd_vsel | output | 2 | CD voltage select |
| aud_vsel | output | 2 | AUDIO voltage select |
| sys_vsel | output | 1 | SYS voltage select |
| acc_thr | output | 2 | ACC detector threshold select |
| uv_thr | output | 2 | Undervoltage detector threshold select |
| pin_mode | output | 1 | Status-pin mode |

## Verification
The bench first writes the voltage selects with all rails off. It then enables only ILM and SYS and writes a pattern that flips every field. This separates the per-field guard from a guard on the whole register, and shows that held fields and updated fields sit side by side in one byte. Further write patterns use a foreign address, an extra trailing byte and an undefined sub-address. Each of these leaves a known register image, so a missing acknowledge, an auto-increment or a stray decode shows up as a changed output. Two reads separate a live flag path from a snapshot: the flags change between the two bytes of the first read, and the second read must then show the new value.

// File: rtl/pwr_i2c_pkg.sv
package pwr_i2c_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_SUBADR,
        ST_SUBACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } bus_state_t;

    localparam logic [7:0] SUB_ENABLE = 8'h00;
    localparam logic [7:0] SUB_VSEL   = 8'h01;
    localparam logic [7:0] SUB_DETCFG = 8'h02;
    localparam int unsigned NUM_RAILS = 5;
    localparam int unsigned NUM_WIDE_SEL = 3;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_p, sda_p, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_p    <= scl_pipe[STAGES-1];
            sda_p    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s    = scl_pipe[STAGES-1];
    assign sda_s    = sda_pipe[STAGES-1];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/pwr_reg_bank.sv
module pwr_reg_bank
    import pwr_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_all,
    input  logic       prot_clr,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [NUM_RAILS-1:0] en_q,
    output logic [7:0] vsel_byte,
    output logic [4:0] det_q
);
    logic [1:0] wide_sel [NUM_WIDE_SEL];
    logic       sys_sel;
    logic       unused_bits;

    assign unused_bits = ^{wr_data[2], wr_data[0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       en_q <= '0;
        else if (clr_all || prot_clr)     en_q <= '0;
        else if (wr_en && wr_addr == SUB_ENABLE) en_q <= wr_data[7:3];
    end

    // Wide selects: ILM (g=0), CD (g=1), AUDIO (g=2); each guarded by its own enable
    for (genvar g = 0; g < NUM_WIDE_SEL; g++) begin : g_wide
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       wide_sel[g] <= '0;
            else if (clr_all) wide_sel[g] <= '0;
            else if (wr_en && wr_addr == SUB_VSEL && !en_q[NUM_RAILS-1-g])
                wide_sel[g] <= wr_data[7-2*g -: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sys_sel <= 1'b0;
        else if (clr_all) sys_sel <= 1'b0;
        else if (wr_en && wr_addr == SUB_VSEL && !en_q[1]) sys_sel <= wr_data[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       det_q <= '0;
        else if (clr_all) det_q <= '0;
        else if (wr_en && wr_addr == SUB_DETCFG) det_q <= wr_data[7:3];
    end

    assign vsel_byte = {wide_sel[0], wide_sel[1], wide_sel[2], sys_sel, 1'b0};
endmodule

// File: rtl/pwr_i2c_regs.sv
module pwr_i2c_regs
    import pwr_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b0001000,
    parameter int         SYNC_STAGES = 2,
    parameter int         FLAG_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              sup_rst,
    input  logic              ovp_trip,
    input  logic [FLAG_W-1:0] flag_in,
    output logic [4:0]        rail_en,
    output logic [1:0]        ilm_vsel,
    output logic [1:0]        cd_vsel,
    output logic [1:0]        aud_vsel,
    output logic              sys_vsel,
    output logic [1:0]        acc_thr,
    output logic [1:0]        uv_thr,
    output logic              pin_mode
);
    localparam int PAD_W = 8 - FLAG_W;

    bus_state_t st, nxt;
    logic [3:0] cnt;
    logic [7:0] sh, sub;
    logic [FLAG_W-1:0] snap;
    logic rw, mack, rd_idx;
    logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic wr_en;
    logic [7:0] vsel_byte;
    logic [4:0] det_q;
    logic byte_done;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    assign byte_done = scl_fall && (cnt == 4'd8);

    always_comb begin
        nxt = st;
        if (stop_ev)       nxt = ST_IDLE;
        else if (start_ev) nxt = ST_DEVADR;
        else begin
            unique case (st)
                ST_IDLE:   nxt = ST_IDLE;
                ST_DEVADR: if (byte_done) nxt = (sh[7:1] == DEV_ADDR) ? ST_DEVACK : ST_SKIP;
                ST_DEVACK: if (scl_fall)  nxt = rw ? ST_RDATA : ST_SUBADR;
                ST_SUBADR: if (byte_done) nxt = ST_SUBACK;
                ST_SUBACK: if (scl_fall)  nxt = ST_WDATA;
                ST_WDATA:  if (byte_done) nxt = ST_WACK;
                ST_WACK:   if (scl_fall)  nxt = ST_SKIP;
                ST_RDATA:  if (scl_fall && cnt == 4'd7) nxt = ST_RACK;
                ST_RACK:   if (scl_fall)  nxt = (mack && !rd_idx) ? ST_RDATA : ST_SKIP;
                ST_SKIP:   nxt = ST_SKIP;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       st <= ST_IDLE;
        else if (sup_rst) st <= ST_IDLE;
        else              st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; sh <= '0; sub <= '0; snap <= '0;
            rw <= 1'b0; mack <= 1'b0; rd_idx <= 1'b0;
        end else if (sup_rst || start_ev || stop_ev) begin
            cnt <= '0;
        end else begin
            unique case (st)
                ST_DEVADR, ST_SUBADR, ST_WDATA: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 4'd1;
                    end else if (byte_done) begin
                        cnt <= '0;
                        if (st == ST_DEVADR) rw  <= sh[0];
                        if (st == ST_SUBADR) sub <= sh;
                    end
                end
                ST_DEVACK: if (scl_fall && rw) begin
                    sh     <= vsel_byte;
                    snap   <= flag_in;
                    rd_idx <= 1'b0;
                    cnt    <= '0;
                end
                ST_RDATA: if (scl_fall) begin
                    sh  <= {sh[6:0], 1'b0};
                    cnt <= (cnt == 4'd7) ? 4'd0 : cnt + 4'd1;
                end
                ST_RACK: begin
                    if (scl_rise) mack <= ~sda_s;
                    else if (scl_fall && mack && !rd_idx) begin
                        sh     <= {snap, {PAD_W{1'b0}}};
                        rd_idx <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign wr_en = (st == ST_WDATA) && byte_done && !sup_rst;

    always_comb begin
        unique case (st)
            ST_DEVACK, ST_SUBACK, ST_WACK: sda_oe = 1'b1;
            ST_RDATA:                      sda_oe = ~sh[7];
            default:                       sda_oe = 1'b0;
        endcase
    end

    pwr_reg_bank u_regs (
        .clk(clk), .rst_n(rst_n), .clr_all(sup_rst), .prot_clr(ovp_trip),
        .wr_en(wr_en), .wr_addr(sub), .wr_data(sh),
        .en_q(rail_en), .vsel_byte(vsel_byte), .det_q(det_q)
    );

    assign ilm_vsel = vsel_byte[7:6];
    assign cd_vsel  = vsel_byte[5:4];
    assign aud_vsel = vsel_byte[3:2];
    assign sys_vsel = vsel_byte[1];
    assign acc_thr  = det_q[4:3];
    assign uv_thr   = det_q[2:1];
    assign pin_mode = det_q[0];
endmodule

// File: rtl/pwr_i2c_regs_chk.sv
module pwr_i2c_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sup_rst,
    input logic       ovp_trip,
    input logic       sda_oe,
    input logic [4:0] rail_en,
    input logic [1:0] ilm_vsel,
    input logic [1:0] cd_vsel,
    input logic [1:0] aud_vsel,
    input logic       sys_vsel,
    input logic [1:0] acc_thr,
    input logic [1:0] uv_thr,
    input logic       pin_mode
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!sda_oe && rail_en == 5'd0);
        end
    end

    a_r11_ovp_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_trip |=> rail_en == 5'd0);

    a_r12_sup_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sup_rst |=> (rail_en == 5'd0 && ilm_vsel == 2'd0 && cd_vsel == 2'd0 &&
                     aud_vsel == 2'd0 && !sys_vsel && acc_thr == 2'd0 &&
                     uv_thr == 2'd0 && !pin_mode));

    a_r5_ilm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en[4] && !sup_rst) |=> $stable(ilm_vsel));

    a_r5_cd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en[3] && !sup_rst) |=> $stable(cd_vsel));

    a_r5_aud_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en[2] && !sup_rst) |=> $stable(aud_vsel));

    a_r5_sys_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en[1] && !sup_rst) |=> $stable(sys_vsel));
endmodule

bind pwr_i2c_regs pwr_i2c_regs_chk u_chk (.*);

// File: tb/tb_pwr_i2c_regs.sv
`timescale 1ns/1ps
module tb_pwr_i2c_regs;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1;
    logic sup_rst = 1'b0, ovp_trip = 1'b0;
    logic [5:0] flag_in = '0;
    logic sda_oe;
    logic [4:0] rail_en;
    logic [1:0] ilm_vsel, cd_vsel, aud_vsel, acc_thr, uv_thr;
    logic sys_vsel, pin_mode;
    wire  sda_bus = sda_m & ~sda_oe;

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    logic [4:0] exp_en = '0;
    logic [7:0] exp_v = '0;
    logic [4:0] exp_det = '0;

    always #2.5 clk = ~clk;

    pwr_i2c_regs dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .sup_rst(sup_rst), .ovp_trip(ovp_trip), .flag_in(flag_in),
        .rail_en(rail_en), .ilm_vsel(ilm_vsel), .cd_vsel(cd_vsel),
        .aud_vsel(aud_vsel), .sys_vsel(sys_vsel), .acc_thr(acc_thr),
        .uv_thr(uv_thr), .pin_mode(pin_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        chk({tag, " enables"}, {27'd0, rail_en}, {27'd0, exp_en});
        chk({tag, " vsel"}, {24'd0, ilm_vsel, cd_vsel, aud_vsel, sys_vsel, 1'b0}, {24'd0, exp_v});
        chk({tag, " detcfg"}, {27'd0, acc_thr, uv_thr, pin_mode}, {27'd0, exp_det});
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(Q);
        scl = 1'b1; wait_q(Q);
        sda_m = 1'b1; wait_q(Q);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wait_q(Q);
        scl = 1'b1; wait_q(Q);
        scl = 1'b0; wait_q(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wait_q(Q);
        scl = 1'b1; wait_q(Q / 2);
        b = sda_bus; wait_q(Q / 2);
        scl = 1'b0; wait_q(Q);
    endtask

    task automatic byte_out(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        acked = ~a;
    endtask

    task automatic byte_in(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(~give_ack);
    endtask

    task automatic wr_txn(input logic [6:0] dev, input logic [7:0] sub, input logic [7:0] dat,
                          output logic ak_a, output logic ak_s, output logic ak_d);
        bus_start();
        byte_out({dev, 1'b0}, ak_a);
        byte_out(sub, ak_s);
        byte_out(dat, ak_d);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R1 sda_oe idle", {31'd0, sda_oe}, 32'd0);
        chk_regs("R1 reset");
    endtask

    task automatic t_foreign_addr();
        logic a, s, d;
        wr_txn(7'b0001001, 8'h00, 8'hF8, a, s, d);
        chk("R2 foreign address nack", {31'd0, a}, 32'd0);
        chk_regs("R2 foreign address no write");
    endtask

    task automatic t_vsel_all_off();
        logic a, s, d;
        wr_txn(7'b0001000, 8'h01, 8'h9E, a, s, d);
        chk("R2 own address ack", {31'd0, a}, 32'd1);
        chk("R4 data ack", {31'd0, d}, 32'd1);
        exp_v = 8'h9E;
        chk_regs("R4 vsel load");
    endtask

    task automatic t_enable();
        logic a, s, d;
        wr_txn(7'b0001000, 8'h00, 8'h97, a, s, d);
        exp_en = 5'b10010;
        chk_regs("R3 enable map, low bits ignored");
    endtask

    task automatic t_vsel_guard();
        logic a, s, d;
        wr_txn(7'b0001000, 8'h01, 8'h21, a, s, d);
        exp_v = 8'hA2;
        chk_regs("R5 enabled fields held");
    endtask

    task automatic t_detcfg();
        logic a, s, d;
        wr_txn(7'b0001000, 8'h02, 8'hDB, a, s, d);
        exp_det = 5'b11011;
        chk_regs("R6 detector config");
    endtask

    task automatic t_extra_byte();
        logic a, s, d, x;
        bus_start();
        byte_out(8'h10, a);
        byte_out(8'h01, s);
        byte_out(8'h1C, d);
        byte_out(8'hFF, x);
        bus_stop();
        chk("R7 first data ack", {31'd0, d}, 32'd1);
        chk("R7 extra byte nack", {31'd0, x}, 32'd0);
        exp_v = 8'h9E;
        chk_regs("R7 no auto-increment");
    endtask

    task automatic t_undef_sub();
        logic a, s, d;
        wr_txn(7'b0001000, 8'h05, 8'hFF, a, s, d);
        chk("R8 undefined sub ack", {31'd0, s}, 32'd1);
        chk("R8 undefined data ack", {31'd0, d}, 32'd1);
        chk_regs("R8 undefined sub discarded");
    endtask

    task automatic t_read(input logic [5:0] f0, input logic [5:0] f1, input string tag);
        logic a;
        logic [7:0] b0, b1;
        flag_in = f0;
        bus_start();
        byte_out(8'h11, a);
        byte_in(b0, 1'b1);
        flag_in = f1;
        byte_in(b1, 1'b0);
        bus_stop();
        chk({tag, " R9 read addr ack"}, {31'd0, a}, 32'd1);
        chk({tag, " R9 first byte vsel"}, {24'd0, b0}, {24'd0, exp_v});
        chk({tag, " R10 flag snapshot"}, {24'd0, b1}, {24'd0, f0, 2'b00});
    endtask

    task automatic t_ovp();
        logic a, s, d;
        @(negedge clk) ovp_trip = 1'b1;
        wait_q(2);
        exp_en = '0;
        chk_regs("R11 ovp during trip");
        ovp_trip = 1'b0;
        wait_q(4);
        chk_regs("R11 ovp not restored");
        wr_txn(7'b0001000, 8'h01, 8'h00, a, s, d);
        exp_v = 8'h00;
        chk_regs("R11 vsel free after trip");
    endtask

    task automatic t_sup_rst();
        logic a, s, d;
        wr_txn(7'b0001000, 8'h01, 8'hFE, a, s, d);
        wr_txn(7'b0001000, 8'h00, 8'hF8, a, s, d);
        exp_v = 8'hFE; exp_en = 5'b11111;
        chk_regs("R12 before supervisor reset");
        @(negedge clk) sup_rst = 1'b1;
        wait_q(2);
        sup_rst = 1'b0;
        wait_q(2);
        exp_v = '0; exp_en = '0; exp_det = '0;
        chk_regs("R12 supervisor reset");
        t_read(6'b000001, 6'b000001, "R12 after");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        wait_q(5);
        t_reset();
        t_foreign_addr();
        t_vsel_all_off();
        t_enable();
        t_vsel_guard();
        t_detcfg();
        t_extra_byte();
        t_undef_sub();
        t_read(6'b101101, 6'b010010, "snap");
        t_read(6'b010010, 6'b010010, "live");
        t_ovp();
        t_sup_rst();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule